// File: doc/BRIEF.md
# Floating-Point Access Gate and No-Coprocessor Fault Router

This block sits beside the instruction decoder of a microcontroller-class core that has a Secure and a Non-Secure state. Each time a floating-point instruction issues, it decides whether the instruction may run. If it may not, it raises a no-coprocessor usage fault and sends that fault to the correct security state.

The decision takes two steps. The first step reads a 2-bit permission field from the access-control register of the current security state. There is one such register for each state. The second step applies only when the security extension is present and the core runs Non-Secure. It checks a gate bit in a Secure-owned register, the non-secure permission register. A denial at the first step faults to the current state. A denial at the second step always faults to the Secure state. The core has no separate global FP-enable bit, so an instruction that passes both steps is allowed.

A simple register port writes all three control registers and clears the per-bank sticky fault flags. A combinational read port returns the register contents. The FPU, exception entry and stacking belong to other blocks.

Top module: `fpu_gate_router`

## Requirements
- R1: After reset, both access-control registers and the non-secure permission register read as zero, both sticky fault flags are 0, no fault is pending, and FP access is denied.
- R2: The permission field sits at bits [21:20] of the access-control register. The copy used is the one for the current state: write select 0 sets the Non-Secure copy and select 1 sets the Secure copy. Read selects use the same encoding.
- R3: Permission value 3 allows every access. Value 1 allows privileged access only. Privilege holds when `handler_mode` is 1 or when `thread_unpriv` is 0.
- R4: Permission values 0 and 2 deny every access, privileged or not.
- R5: With `sec_ext_present` high and `cur_secure` low, an access that passes the permission field still needs bit 10 of the non-secure permission register (write or read select 2). If that bit is clear, the access is denied and the fault targets the Secure state.
- R6: The permission field is checked before the gate. A permission denial targets the current state even when the gate bit is also clear.
- R7: With `sec_ext_present` low, the gate bit has no effect.
- R8: A denied `fp_issue` causes `fault_pend` to be high for exactly one cycle, on the cycle after the strobe. `fault_to_secure` is valid in that same cycle. An allowed issue, or no issue, never causes `fault_pend`.
- R9: A fault sets the sticky flag of its target bank (`nocp_s` or `nocp_ns`). A flag clears only when write select 3 is written with data bit 0 set (clears the Non-Secure flag) or data bit 1 set (clears the Secure flag). If a set and a clear fall in the same cycle, the set wins. Read select 3 returns {Secure flag, Non-Secure flag} in bits [1:0].
- R10: A write to the non-secure permission register is accepted only when `wr_from_secure` is 1. A write with `wr_from_secure` at 0 leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_ext_present | input | 1 | Security extension implemented |
| cur_secure | input | 1 | Core is in Secure state |
| handler_mode | input | 1 | Core is in handler mode |
| thread_unpriv | input | 1 | Thread mode runs unprivileged |
| fp_issue | input | 1 | Floating-point instruction issue strobe |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Write target: 0 NS access, 1 S access, 2 NS permission, 3 fault-flag clear |
| wr_from_secure | input | 1 | The write comes from Secure state |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_data | output | 32 | Read data |
| fp_allow | output | 1 | The current FP access is permitted |
| fault_pend | output | 1 | One-cycle no-coprocessor usage-fault request |
| fault_to_secure | output | 1 | Fault targets the Secure state |
| nocp_ns | output | 1 | Sticky no-coprocessor flag, Non-Secure bank |
| nocp_s | output | 1 | Sticky no-coprocessor flag, Secure bank |

## Verification
Each permission value is tried with privileged thread, unprivileged thread and handler access. This separates the privileged-only encoding from full access and shows that the reserved value behaves as a denial. The same permission settings are then applied in the two security states with different bank contents, which shows that the bank follows `cur_secure`. Gate cases pair a passing permission field with a clear gate bit, then a failing permission field with a clear gate bit. Together these fix both the Secure fault target and the order of the two checks. Repeating the gate case with the extension absent, and trying a Non-Secure write to the gate register, shows both to be ignored.

// File: rtl/fpu_gate_pkg.sv
package fpu_gate_pkg;
  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_PRIV = 2'd1,
    PERM_RSVD = 2'd2,
    PERM_ALL  = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    SEL_ACC_NS = 2'd0,
    SEL_ACC_S  = 2'd1,
    SEL_NSPERM = 2'd2,
    SEL_FLAGS  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fgr_ctrl_regs.sv
module fgr_ctrl_regs
  import fpu_gate_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic              wr_from_secure,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] acc_ns,
  output logic [DATA_W-1:0] acc_s,
  output logic [DATA_W-1:0] nsperm
);
  logic              en_ns, en_s, en_np;
  logic [DATA_W-1:0] acc_ns_q, acc_s_q, nsperm_q;

  always_comb begin
    en_ns = wr_en && (wr_sel == SEL_ACC_NS);
    en_s  = wr_en && (wr_sel == SEL_ACC_S);
    en_np = wr_en && (wr_sel == SEL_NSPERM) && wr_from_secure;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_ns_q <= '0;
      acc_s_q  <= '0;
      nsperm_q <= '0;
    end else begin
      if (en_ns) acc_ns_q <= wr_data;
      if (en_s)  acc_s_q  <= wr_data;
      if (en_np) nsperm_q <= wr_data;
    end
  end

  assign acc_ns = acc_ns_q;
  assign acc_s  = acc_s_q;
  assign nsperm = nsperm_q;

  assert_ns_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_NSPERM && !wr_from_secure) |=> $stable(nsperm_q));
endmodule

// File: rtl/fgr_perm_eval.sv
module fgr_perm_eval
  import fpu_gate_pkg::*;
(
  input  logic [1:0] perm_ns,
  input  logic [1:0] perm_s,
  input  logic       gate_bit,
  input  logic       cur_secure,
  input  logic       is_priv,
  input  logic       sec_ext,
  output logic       allow,
  output logic       deny_to_secure
);
  perm_e perm_cur;
  logic  field_ok, gate_block;

  always_comb begin
    perm_cur = perm_e'(cur_secure ? perm_s : perm_ns);
    unique case (perm_cur)
      PERM_ALL:  field_ok = 1'b1;
      PERM_PRIV: field_ok = is_priv;
      default:   field_ok = 1'b0;   // none and reserved both deny
    endcase
    gate_block = sec_ext && !cur_secure && !gate_bit;
    allow      = field_ok && !gate_block;
    // field denial goes to the current state; gate denial always to Secure
    deny_to_secure = field_ok ? 1'b1 : cur_secure;
  end
endmodule

// File: rtl/fgr_fault_status.sv
module fgr_fault_status (
  input  logic clk,
  input  logic rst_n,
  input  logic fp_issue,
  input  logic allow,
  input  logic deny_to_secure,
  input  logic clr_ns,
  input  logic clr_s,
  output logic fault_pend,
  output logic fault_to_secure,
  output logic nocp_ns,
  output logic nocp_s
);
  logic fault_now;
  logic pend_d, tgt_d, ns_d, s_d;
  logic pend_q, tgt_q, ns_q, s_q;

  always_comb begin
    fault_now = fp_issue && !allow;
    pend_d    = fault_now;
    tgt_d     = fault_now ? deny_to_secure : tgt_q;
    ns_d      = (ns_q && !clr_ns) || (fault_now && !deny_to_secure);
    s_d       = (s_q  && !clr_s)  || (fault_now &&  deny_to_secure);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tgt_q  <= 1'b0;
      ns_q   <= 1'b0;
      s_q    <= 1'b0;
    end else begin
      pend_q <= pend_d;
      tgt_q  <= tgt_d;
      ns_q   <= ns_d;
      s_q    <= s_d;
    end
  end

  assign fault_pend      = pend_q;
  assign fault_to_secure = tgt_q;
  assign nocp_ns         = ns_q;
  assign nocp_s          = s_q;

  assert_pend_follows_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> $past(fp_issue));
  assert_secure_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && tgt_q) |-> s_q);
  assert_nonsecure_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !tgt_q) |-> ns_q);
endmodule

// File: rtl/fpu_gate_router.sv
module fpu_gate_router
  import fpu_gate_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PERM_LSB = 20,
  parameter int GATE_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_ext_present,
  input  logic              cur_secure,
  input  logic              handler_mode,
  input  logic              thread_unpriv,
  input  logic              fp_issue,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic              wr_from_secure,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              fp_allow,
  output logic              fault_pend,
  output logic              fault_to_secure,
  output logic              nocp_ns,
  output logic              nocp_s
);
  localparam int FLAG_PAD = DATA_W - 2;

  // asynchronous assertion, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [DATA_W-1:0] acc_ns, acc_s, nsperm;
  logic              is_priv, deny_to_secure, clr_ns, clr_s;

  fgr_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_from_secure(wr_from_secure), .wr_data(wr_data),
    .acc_ns(acc_ns), .acc_s(acc_s), .nsperm(nsperm)
  );

  always_comb begin
    is_priv = handler_mode || !thread_unpriv;
    clr_ns  = wr_en && (wr_sel == SEL_FLAGS) && wr_data[0];
    clr_s   = wr_en && (wr_sel == SEL_FLAGS) && wr_data[1];
  end

  fgr_perm_eval u_eval (
    .perm_ns(acc_ns[PERM_LSB +: 2]), .perm_s(acc_s[PERM_LSB +: 2]),
    .gate_bit(nsperm[GATE_BIT]), .cur_secure(cur_secure), .is_priv(is_priv),
    .sec_ext(sec_ext_present), .allow(fp_allow), .deny_to_secure(deny_to_secure)
  );

  fgr_fault_status u_status (
    .clk(clk), .rst_n(rst_sync_n), .fp_issue(fp_issue), .allow(fp_allow),
    .deny_to_secure(deny_to_secure), .clr_ns(clr_ns), .clr_s(clr_s),
    .fault_pend(fault_pend), .fault_to_secure(fault_to_secure),
    .nocp_ns(nocp_ns), .nocp_s(nocp_s)
  );

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_ACC_NS: rd_data = acc_ns;
      SEL_ACC_S:  rd_data = acc_s;
      SEL_NSPERM: rd_data = nsperm;
      default:    rd_data = {{FLAG_PAD{1'b0}}, nocp_s, nocp_ns};
    endcase
  end

  assert_deny_codes_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((cur_secure ? acc_s[PERM_LSB] : acc_ns[PERM_LSB]) == 1'b0) |-> !fp_allow);
  assert_gate_blocks_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sec_ext_present && !cur_secure && !nsperm[GATE_BIT]) |-> !fp_allow);
  assert_allowed_no_fault_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fp_issue && fp_allow) |=> !fault_pend);
endmodule

// File: tb/fpu_gate_router_bench.sv
`timescale 1ns/1ps
module fpu_gate_router_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sec_ext_present, cur_secure, handler_mode, thread_unpriv, fp_issue;
  logic        wr_en, wr_from_secure;
  logic [1:0]  wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic        fp_allow, fault_pend, fault_to_secure, nocp_ns, nocp_s;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] sh_acc_ns, sh_acc_s, sh_np;
  bit sh_fns, sh_fs;

  always #2 clk = ~clk;

  fpu_gate_router u_fpu_gate_router (
    .clk(clk), .rst_n(rst_n), .sec_ext_present(sec_ext_present),
    .cur_secure(cur_secure), .handler_mode(handler_mode),
    .thread_unpriv(thread_unpriv), .fp_issue(fp_issue), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_from_secure(wr_from_secure), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .fp_allow(fp_allow),
    .fault_pend(fault_pend), .fault_to_secure(fault_to_secure),
    .nocp_ns(nocp_ns), .nocp_s(nocp_s)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] perm_word(input logic [1:0] p);
    return {10'd0, p, 20'd0};
  endfunction

  task automatic write_reg(input logic [1:0] sel, input logic [31:0] d, input bit from_s);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; wr_from_secure = from_s;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'd0: sh_acc_ns = d;
      2'd1: sh_acc_s = d;
      2'd2: if (from_s) sh_np = d;
      default: begin
        if (d[0]) sh_fns = 0;
        if (d[1]) sh_fs = 0;
      end
    endcase
  endtask

  task automatic check_rd(input logic [1:0] sel, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    rd_sel = sel;
    #0.5;
    case (sel)
      2'd0: exp = sh_acc_ns;
      2'd1: exp = sh_acc_s;
      2'd2: exp = sh_np;
      default: exp = {30'd0, sh_fs, sh_fns};
    endcase
    chk(rd_data === exp, tag, rd_data, exp);
  endtask

  // Issue one FP instruction and check allow, the fault pulse, its target and the flags
  task automatic do_fp(input bit sec, input bit hnd, input bit tunp, input string tag);
    logic [1:0] p;
    bit priv, ok, ea, et;
    @(negedge clk);
    cur_secure = sec; handler_mode = hnd; thread_unpriv = tunp;
    p    = sec ? sh_acc_s[21:20] : sh_acc_ns[21:20];
    priv = hnd || !tunp;
    ok   = (p == 2'd3) || (p == 2'd1 && priv);
    if (!ok) begin ea = 0; et = sec; end
    else if (sec_ext_present && !sec && !sh_np[10]) begin ea = 0; et = 1; end
    else begin ea = 1; et = 0; end
    #0.5;
    chk(fp_allow === ea, {tag, " allow"}, 32'(fp_allow), 32'(ea));
    fp_issue = 1'b1;
    @(negedge clk);
    fp_issue = 1'b0;
    chk(fault_pend === !ea, {tag, " R8 pend"}, 32'(fault_pend), 32'(!ea));
    if (!ea) begin
      chk(fault_to_secure === et, {tag, " target"}, 32'(fault_to_secure), 32'(et));
      if (et) sh_fs = 1; else sh_fns = 1;
    end
    chk({nocp_s, nocp_ns} === {sh_fs, sh_fns}, {tag, " R9 flags"},
        32'({nocp_s, nocp_ns}), 32'({sh_fs, sh_fns}));
    @(negedge clk);
    chk(fault_pend === 1'b0, {tag, " R8 single pulse"}, 32'(fault_pend), 32'd0);
  endtask

  task automatic t_reset;
    check_rd(2'd0, "R1 acc ns");
    check_rd(2'd1, "R1 acc s");
    check_rd(2'd2, "R1 nsperm");
    check_rd(2'd3, "R1 flags");
    chk(fault_pend === 1'b0, "R1 pend", 32'(fault_pend), 0);
    do_fp(0, 1, 0, "R1 deny after reset");
  endtask

  task automatic t_levels;
    write_reg(2'd0, perm_word(2'd1), 0);
    do_fp(0, 0, 0, "R3 priv thread level1");
    do_fp(0, 0, 1, "R3 unpriv thread level1");
    do_fp(0, 1, 1, "R3 handler level1");
    write_reg(2'd0, perm_word(2'd3), 0);
    do_fp(0, 0, 1, "R3 unpriv level3");
    write_reg(2'd0, perm_word(2'd2), 0);
    do_fp(0, 1, 0, "R4 reserved handler");
    do_fp(0, 0, 0, "R4 reserved thread");
  endtask

  task automatic t_banks;
    write_reg(2'd1, perm_word(2'd3), 1);
    write_reg(2'd0, perm_word(2'd0), 0);
    do_fp(1, 0, 1, "R2 secure bank full");
    do_fp(0, 1, 0, "R2 nonsecure bank none");
    check_rd(2'd1, "R2 read secure bank");
  endtask

  task automatic t_flags;
    write_reg(2'd3, 32'h1, 1);
    check_rd(2'd3, "R9 clear ns flag");
    write_reg(2'd3, 32'h2, 0);
    check_rd(2'd3, "R9 clear s flag");
    // Same-cycle fault and clear: the set wins
    @(negedge clk);
    cur_secure = 0; handler_mode = 1; thread_unpriv = 0;
    fp_issue = 1; wr_en = 1; wr_sel = 2'd3; wr_data = 32'h3;
    @(negedge clk);
    fp_issue = 0; wr_en = 0;
    chk(nocp_ns === 1'b1, "R9 set wins over clear", 32'(nocp_ns), 1);
    sh_fns = 1; sh_fs = 0;
    @(negedge clk);
  endtask

  task automatic t_gate;
    sec_ext_present = 1;
    write_reg(2'd0, perm_word(2'd3), 0);
    do_fp(0, 0, 1, "R5 gate clear to secure");
    do_fp(1, 0, 1, "R5 secure unaffected by gate");
    write_reg(2'd0, perm_word(2'd0), 0);
    do_fp(0, 1, 0, "R6 field denial first");
    write_reg(2'd2, 32'h400, 1);
    write_reg(2'd0, perm_word(2'd3), 0);
    do_fp(0, 0, 1, "R5 gate set allows");
    write_reg(2'd2, 32'h0, 0);
    check_rd(2'd2, "R10 ns write ignored");
    do_fp(0, 0, 1, "R10 gate still open");
    write_reg(2'd2, 32'h0, 1);
    do_fp(0, 0, 1, "R5 gate closed by secure");
    sec_ext_present = 0;
    do_fp(0, 0, 1, "R7 no extension gate ignored");
  endtask

  task automatic t_idle;
    write_reg(2'd0, perm_word(2'd0), 0);
    @(negedge clk);
    cur_secure = 0; fp_issue = 0;
    repeat (3) @(negedge clk);
    chk(fault_pend === 1'b0, "R8 no issue no fault", 32'(fault_pend), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sec_ext_present = 0; cur_secure = 0; handler_mode = 0;
    thread_unpriv = 0; fp_issue = 0; wr_en = 0; wr_sel = 0;
    wr_from_secure = 0; wr_data = 0; rd_sel = 0;
    sh_acc_ns = 0; sh_acc_s = 0; sh_np = 0; sh_fns = 0; sh_fs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset;
    t_levels;
    t_banks;
    t_flags;
    t_gate;
    t_idle;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule